// File: doc/BRIEF.md
# Console CPU Bus Address Decoder

This block sits between an 8-bit-data, 16-bit-address CPU bus and the three memory-mapped targets of a retro console: a 2 KB work RAM, an eight-entry picture-unit register file and a cartridge program ROM. In every cycle it classifies the CPU address, raises the chip select of the addressed target and gives that target a folded local address. All address mirroring is applied here, so each target only ever sees its true local offset.

A configuration input states whether the cartridge carries 16 KB or 32 KB of program ROM. In the 16 KB case the upper 16 KB of the ROM window shows the same bytes as the lower 16 KB. The block returns read data one cycle after the address, steered from the target that was read. This matches targets with a one-cycle synchronous read. A read of the unpopulated window returns zero. The block has no bank switching and holds no storage arrays of its own.

Top module: `cpu_bus_decoder`

## Requirements
- R1: An address in 0x0000–0x1FFF asserts `ram_cs` with `ram_addr` equal to the address modulo 0x0800, so the stack page 0x0100–0x01FF and its copies at 0x0900, 0x1100 and 0x1900 reach the same RAM bytes.
- R2: An address in 0x2000–0x3FFF asserts `pic_cs` with `pic_reg` equal to address bits 2:0, which repeats the eight registers every 8 bytes.
- R3: An address in 0x8000–0xFFFF asserts `rom_cs`. With `rom_is_16k` = 0, `rom_addr` equals address bits 14:0.
- R4: With `rom_is_16k` = 1, `rom_addr` bit 14 is 0 and bits 13:0 follow the address, so 0xC000+n reads the same byte as 0x8000+n.
- R5: `cpu_rw` = 1 means read and 0 means write. `ram_we` or `pic_we` is high only in a write cycle to its own region, with `tgt_wdata` equal to `cpu_wdata`. A write to the ROM window raises no write strobe and leaves the ROM bytes unchanged.
- R6: An address in 0x4000–0x7FFF asserts no chip select and no write strobe. A read there gives `cpu_rdata` = 0x00 in the next cycle.
- R7: At most one chip select is high in any cycle. Exactly one is high for every mapped address, in the same cycle as the address.
- R8: For a read cycle to a mapped target, `cpu_rdata` in the following cycle carries that target's read data. After a write cycle, `cpu_rdata` is 0x00.
- R9: While `rst` is high, the read steering is cleared and `cpu_rdata` stays 0x00 even when a read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data |
| rom_is_16k | input | 1 | 1 = 16 KB program ROM image, 0 = 32 KB |
| ram_rdata | input | 8 | RAM read data, one cycle after select |
| pic_rdata | input | 8 | Picture register read data, one cycle after select |
| rom_rdata | input | 8 | ROM read data, one cycle after select |
| ram_cs | output | 1 | Work RAM select |
| ram_we | output | 1 | Work RAM write strobe |
| ram_addr | output | 11 | Folded RAM offset |
| pic_cs | output | 1 | Picture register select |
| pic_we | output | 1 | Picture register write strobe |
| pic_reg | output | 3 | Picture register index |
| rom_cs | output | 1 | Program ROM select |
| rom_addr | output | 15 | Folded ROM offset |
| tgt_wdata | output | 8 | Write data to targets |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
A wrong region decision or fold shows at once, in the same cycle as the address. It appears as a wrong select, a second select or a mismatched local offset. It also corrupts the data of a later read to the aliased location. A wrong steering register shows one cycle later, as read data taken from the wrong target or a nonzero value after an unmapped read or a write. Mirror faults are exposed by writing through one alias and reading through another, across the RAM, the register file and the 16 KB ROM case.

// File: rtl/cpu_bus_dec_pkg.sv
package cpu_bus_dec_pkg;

    localparam int CPU_AW = 16;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_PIC  = 2'd2,
        TGT_ROM  = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic wr;
    } access_t;

    // Region is decided by the top three address bits:
    // 1xx ROM, 000 RAM, 001 picture registers, 01x unpopulated.
    function automatic tgt_e classify(input logic [CPU_AW-1:0] a);
        tgt_e t;
        casez (a[CPU_AW-1 -: 3])
            3'b1??:  t = TGT_ROM;
            3'b000:  t = TGT_RAM;
            3'b001:  t = TGT_PIC;
            default: t = TGT_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/cbd_region.sv
module cbd_region
    import cpu_bus_dec_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  logic              rw,
    output access_t           acc
);
    always_comb begin
        acc.tgt = classify(addr);
        acc.wr  = ~rw;
    end
endmodule

// File: rtl/cbd_fold.sv
module cbd_fold
    import cpu_bus_dec_pkg::*;
#(
    parameter int RAM_AW = 11,
    parameter int PIC_AW = 3,
    parameter int ROM_AW = 15
) (
    input  logic [CPU_AW-1:0] addr,
    input  logic              rom_is_16k,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [PIC_AW-1:0] pic_reg,
    output logic [ROM_AW-1:0] rom_addr
);
    localparam int BANK_BIT = ROM_AW - 1;

    assign ram_addr = addr[RAM_AW-1:0];
    assign pic_reg  = addr[PIC_AW-1:0];

    genvar i;
    generate
        for (i = 0; i < ROM_AW; i++) begin : g_rom_bit
            if (i == BANK_BIT) begin : g_bank
                assign rom_addr[i] = addr[i] & ~rom_is_16k;
            end else begin : g_pass
                assign rom_addr[i] = addr[i];
            end
        end
    endgenerate
endmodule

// File: rtl/cbd_rsteer.sv
module cbd_rsteer
    import cpu_bus_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] pic_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [DATA_W-1:0] cpu_rdata
);
    tgt_e sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= TGT_NONE;
        else if (acc.wr)
            sel_q <= TGT_NONE;
        else
            sel_q <= acc.tgt;
    end

    always_comb begin
        unique case (sel_q)
            TGT_RAM: cpu_rdata = ram_rdata;
            TGT_PIC: cpu_rdata = pic_rdata;
            TGT_ROM: cpu_rdata = rom_rdata;
            default: cpu_rdata = '0;
        endcase
    end

    assert_wr_zero_R8: assert property (@(posedge clk) disable iff (rst)
        acc.wr |=> (cpu_rdata == '0));

    assert_reset_zero_R9: assert property (@(posedge clk)
        rst |=> (cpu_rdata == '0));
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
    import cpu_bus_dec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RAM_AW = 11,
    parameter int PIC_AW = 3,
    parameter int ROM_AW = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rw,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              rom_is_16k,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] pic_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              pic_cs,
    output logic              pic_we,
    output logic [PIC_AW-1:0] pic_reg,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic [DATA_W-1:0] cpu_rdata
);
    access_t acc;

    cbd_region u_region (
        .addr (cpu_addr),
        .rw   (cpu_rw),
        .acc  (acc)
    );

    cbd_fold #(.RAM_AW(RAM_AW), .PIC_AW(PIC_AW), .ROM_AW(ROM_AW)) u_fold (
        .addr       (cpu_addr),
        .rom_is_16k (rom_is_16k),
        .ram_addr   (ram_addr),
        .pic_reg    (pic_reg),
        .rom_addr   (rom_addr)
    );

    cbd_rsteer #(.DATA_W(DATA_W)) u_rsteer (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .ram_rdata (ram_rdata),
        .pic_rdata (pic_rdata),
        .rom_rdata (rom_rdata),
        .cpu_rdata (cpu_rdata)
    );

    assign ram_cs    = (acc.tgt == TGT_RAM);
    assign pic_cs    = (acc.tgt == TGT_PIC);
    assign rom_cs    = (acc.tgt == TGT_ROM);
    assign ram_we    = ram_cs & acc.wr;
    assign pic_we    = pic_cs & acc.wr;
    assign tgt_wdata = cpu_wdata;

    assert_one_cs_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_cs, pic_cs, rom_cs}));

    assert_mapped_cs_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] != 2'b01) |-> $onehot({ram_cs, pic_cs, rom_cs}));

    assert_ram_fold_R1: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> (ram_addr == cpu_addr[10:0]));

    assert_rom_mirror_R4: assert property (@(posedge clk) disable iff (rst)
        (rom_cs && rom_is_16k) |-> !rom_addr[ROM_AW-1]);

    assert_we_read_R5: assert property (@(posedge clk) disable iff (rst)
        (ram_we || pic_we) |-> !cpu_rw);

    assert_unmapped_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b01) |-> !(ram_cs || pic_cs || rom_cs));

    assert_unmapped_rd_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b01 && cpu_rw) |=> (cpu_rdata == '0));
endmodule

// File: tb/cpu_bus_decoder_tb.sv
`timescale 1ns/1ps
module cpu_bus_decoder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        cpu_rw;
    logic [7:0]  cpu_wdata;
    logic        rom_is_16k;
    logic [7:0]  ram_rdata, pic_rdata, rom_rdata;
    logic        ram_cs, ram_we, pic_cs, pic_we, rom_cs;
    logic [10:0] ram_addr;
    logic [2:0]  pic_reg;
    logic [14:0] rom_addr;
    logic [7:0]  tgt_wdata, cpu_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    cpu_bus_decoder u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_wdata(cpu_wdata), .rom_is_16k(rom_is_16k),
        .ram_rdata(ram_rdata), .pic_rdata(pic_rdata), .rom_rdata(rom_rdata),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
        .pic_cs(pic_cs), .pic_we(pic_we), .pic_reg(pic_reg),
        .rom_cs(rom_cs), .rom_addr(rom_addr),
        .tgt_wdata(tgt_wdata), .cpu_rdata(cpu_rdata)
    );

    // Behavioural targets driven only by the decoder outputs.
    logic [7:0] ram_mem [2048];
    logic [7:0] pic_mem [8];

    function automatic logic [7:0] rom_byte(input logic [14:0] l);
        return l[7:0] ^ {1'b1, l[14:8]};
    endfunction

    always @(posedge clk) begin
        if (ram_cs) begin
            ram_rdata <= ram_mem[ram_addr];
            if (ram_we) ram_mem[ram_addr] <= tgt_wdata;
        end
        if (pic_cs) begin
            pic_rdata <= pic_mem[pic_reg];
            if (pic_we) pic_mem[pic_reg] <= tgt_wdata;
        end
        if (rom_cs) rom_rdata <= rom_byte(rom_addr);
    end

    // Independent shadow of the expected contents.
    logic [7:0] ram_ref [2048];
    logic [7:0] pic_ref [8];

    function automatic int region(input logic [15:0] a);
        if (a < 16'h2000)      return 1;
        else if (a < 16'h4000) return 2;
        else if (a < 16'h8000) return 0;
        else                   return 3;
    endfunction

    function automatic string rtag(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return (rom_is_16k ? "R4" : "R3");
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input bit rd, input logic [7:0] wd);
        int r;
        int exp_rd;
        r = region(a);
        cpu_addr = a; cpu_rw = rd; cpu_wdata = wd;
        #1;
        check({ram_cs, pic_cs, rom_cs} == {r == 1, r == 2, r == 3}, rtag(r),
              "select", {ram_cs, pic_cs, rom_cs}, {r == 1, r == 2, r == 3});
        check($countones({ram_cs, pic_cs, rom_cs}) == (r != 0 ? 1 : 0), "R7",
              "select count", $countones({ram_cs, pic_cs, rom_cs}), (r != 0));
        check({ram_we, pic_we} == {r == 1 && !rd, r == 2 && !rd}, "R5",
              "write strobes", {ram_we, pic_we}, {r == 1 && !rd, r == 2 && !rd});
        if (!rd && r != 0 && r != 3)
            check(tgt_wdata == wd, "R5", "wdata", tgt_wdata, wd);
        exp_rd = 0;
        case (r)
            1: begin
                check(ram_addr == a % 16'h0800, "R1", "ram_addr", ram_addr, a % 16'h0800);
                exp_rd = ram_ref[a % 16'h0800];
                if (!rd) ram_ref[a % 16'h0800] = wd;
            end
            2: begin
                check(pic_reg == a % 8, "R2", "pic_reg", pic_reg, a % 8);
                exp_rd = pic_ref[a % 8];
                if (!rd) pic_ref[a % 8] = wd;
            end
            3: begin
                logic [14:0] l;
                l = rom_is_16k ? {1'b0, a[13:0]} : a[14:0];
                check(rom_addr == l, rtag(r), "rom_addr", rom_addr, l);
                exp_rd = rom_byte(l);
            end
            default: ;
        endcase
        if (!rd) exp_rd = 0;
        @(negedge clk);
        check(cpu_rdata == exp_rd[7:0], rd ? ((r == 0) ? "R6" : "R8") : "R8",
              "read data", cpu_rdata, exp_rd);
    endtask

    initial begin : watchdog
        #500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] first;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 2048; i++) begin ram_mem[i] = 8'h00; ram_ref[i] = 8'h00; end
        for (int i = 0; i < 8; i++) begin pic_mem[i] = 8'h00; pic_ref[i] = 8'h00; end
        ram_rdata = 0; pic_rdata = 0; rom_rdata = 0;
        rst = 1'b1; cpu_addr = 16'h0000; cpu_rw = 1'b1; cpu_wdata = 0; rom_is_16k = 1'b0;
        repeat (3) @(negedge clk);
        cpu_addr = 16'h8005;
        @(negedge clk);
        check(cpu_rdata == 8'h00, "R9", "rdata in reset", cpu_rdata, 0);
        rst = 1'b0;

        // Directed cases, 32 KB image.
        access(16'h0000, 0, 8'hA5);
        access(16'h0800, 1, 8'h00);
        access(16'h01FF, 0, 8'h3C);
        access(16'h19FF, 1, 8'h00);
        access(16'h0100, 0, 8'h77);
        access(16'h0900, 1, 8'h00);
        access(16'h2003, 0, 8'h5A);
        access(16'h3FFB, 1, 8'h00);
        access(16'h4000, 1, 8'h00);
        access(16'h7FFF, 1, 8'h00);
        access(16'h5000, 0, 8'hFF);
        access(16'h8000, 0, 8'h99);
        access(16'h8000, 1, 8'h00);
        access(16'hFFFF, 1, 8'h00);
        access(16'hC123, 1, 8'h00);
        for (int i = 0; i < 600; i++)
            access(16'($urandom), 1'($urandom), 8'($urandom));

        // 16 KB image: upper bank mirrors lower.
        rom_is_16k = 1'b1;
        access(16'h8123, 1, 8'h00);
        first = cpu_rdata;
        access(16'hC123, 1, 8'h00);
        check(cpu_rdata == first, "R4", "upper mirror", cpu_rdata, first);
        access(16'hFFFF, 0, 8'h12);
        access(16'hFFFF, 1, 8'h00);
        for (int i = 0; i < 600; i++)
            access(16'($urandom), 1'($urandom), 8'($urandom));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule